// File: doc/BRIEF.md
# Oversampled Start-of-Frame Character Receiver

This block recovers reader-to-tag frames from a one-bit envelope that is sampled four times per elementary time unit (etu). Each accepted sample arrives with a strobe. A frame opens with a long low run (the start-of-frame). A bounded high guard follows, and then come 10-bit characters. Each character is one low start bit, eight data bits sent least significant first, and one high stop bit. A character whose ten sampled bits are all zero closes the frame.

Decoded bytes leave on a simple write port: an enable, an address that counts up from zero, and the data byte. When the frame closes, a one-cycle pulse carries the number of bytes received. An active flag shows that a start-of-frame has been accepted and the frame is still open. Any timing violation drops the block back to hunting for a new start-of-frame. Analog demodulation and any checksum are handled elsewhere.

Top module: `sfr_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `wr_en_o`, `done_o`, `active_o` and `done_len_o` are all zero.
- R2: A start-of-frame is accepted when 10, 11 or 12 consecutive low etus are followed by a high etu. Sampling is done at the third sample of each etu, counted from the first low sample. `active_o` goes high in the cycle after the sample that accepts it.
- R3: A low run of 9 or fewer etus before the high is rejected, and the frame that follows writes no byte and raises no done pulse.
- R4: A low run of 13 or more etus is rejected when the 13th low etu is sampled, and the frame that follows writes no byte and raises no done pulse.
- R5: Inside a character each bit is taken from the second sample of its etu, counted from the falling start edge. A character with start bit 0 and stop bit 1 yields the byte made of its eight data bits in order, least significant first. That byte is written once, with `wr_addr_o` equal to its index in the frame (0 for the first byte), one cycle after the strobe that carried the stop bit.
- R6: When the block is waiting for a start bit, up to 25 consecutive high samples are tolerated. The 26th high sample abandons the frame. This applies both after the start-of-frame and between characters.
- R7: A character of ten zero bits that follows at least one byte produces a single-cycle `done_o` with `done_len_o` equal to the byte count, and `wr_en_o` is not raised for it.
- R8: An all-zero character that arrives before any byte closes the frame without a done pulse.
- R9: The byte that brings the count to MAX_BYTES is still written, and then the frame is abandoned with no done pulse. The longest frame that can complete is therefore MAX_BYTES-1 bytes.
- R10: A character that is neither a valid byte nor all zero (for example, one with stop bit 0) is not written, and it abandons the frame with no done pulse.
- R11: `active_o` is low while the block hunts for a start-of-frame. It is high from an accepted start-of-frame until the frame closes or is abandoned, and it is already low in the cycle where `done_o` is high.
- R12: `samp_i` is ignored in any cycle where `samp_vld_i` is low. Counters, state and outputs change only because of strobed samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_vld_i | input | 1 | Strobe: `samp_i` holds a new sample this cycle |
| samp_i | input | 1 | Sampled envelope bit, four samples per etu |
| wr_en_o | output | 1 | Byte write enable, one cycle per decoded byte |
| wr_addr_o | output | $clog2(MAX_BYTES) | Index of the byte within the frame |
| wr_data_o | output | CHR_BITS-2 | Decoded byte |
| active_o | output | 1 | Frame open (start-of-frame accepted, not yet closed) |
| done_o | output | 1 | One-cycle pulse at a completed frame |
| done_len_o | output | $clog2(MAX_BYTES+1) | Byte count of the completed frame, valid with `done_o` |

## Verification
The bench builds the block with MAX_BYTES set to 6 and keeps the other timing parameters at their defaults: 4 samples per etu, start-of-frame limits of 10 and 12 etus, and a gap limit of 25 samples. The small byte limit means that random frames of up to eight bytes regularly hit the overflow abandon, and a five-byte frame exercises the longest frame that can still complete. Because the gap limit stays at its default, guard lengths of 7 and 8 etus and character gaps of 5 and 6 etus fall exactly on either side of the 25-sample timeout. Strobes are spaced by random stalls, and `samp_i` is driven with noise in the idle cycles between them.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  // Receiver phases: hunting, start-of-frame low run, waiting for a start bit, inside a character
  typedef enum logic [1:0] {
    SFR_IDLE = 2'd0,
    SFR_SOF  = 2'd1,
    SFR_GAP  = 2'd2,
    SFR_CHR  = 2'd3
  } sfr_state_e;
endpackage

// File: rtl/sfr_chr_shift.sv
module sfr_chr_shift #(
  parameter int CHR_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                shift_i,
  input  logic                bit_i,
  output logic                is_byte_o,
  output logic                is_end_o,
  output logic [CHR_BITS-3:0] byte_o
);
  logic [CHR_BITS-1:0] sh_q;
  logic [CHR_BITS-1:0] sh_d;
  logic [CHR_BITS-1:0] nxt;

  // New bit enters at the top; after a full character the start bit sits at bit 0
  always_comb begin
    nxt  = {bit_i, sh_q[CHR_BITS-1:1]};
    sh_d = sh_q;
    if (clr_i)        sh_d = '0;
    else if (shift_i) sh_d = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sh_q <= '0;
    else if (clr_i | shift_i) sh_q <= sh_d;
  end

  // Classification looks at the value including the bit being sampled now
  always_comb begin
    is_byte_o = nxt[CHR_BITS-1] & ~nxt[0];
    is_end_o  = ~|nxt;
    byte_o    = nxt[CHR_BITS-2:1];
  end
endmodule

// File: rtl/sfr_byte_ctr.sv
module sfr_byte_ctr #(
  parameter int MAX_BYTES = 256,
  parameter int CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output logic          any_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (clr_i | inc_i) cnt_q <= cnt_d;
  end

  always_comb begin
    cnt_o  = cnt_q;
    last_o = (int'(cnt_q) >= MAX_BYTES - 1);
    any_o  = |cnt_q;
  end
endmodule

// File: rtl/sfr_ctl.sv
module sfr_ctl
  import sfr_pkg::*;
#(
  parameter int SAMP_PER_ETU = 4,
  parameter int SOF_MIN_ETU  = 10,
  parameter int SOF_MAX_ETU  = 12,
  parameter int GAP_MAX_SAMP = 25,
  parameter int CHR_BITS     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  logic bit_i,
  input  logic chr_byte_i,
  input  logic chr_end_i,
  input  logic cnt_last_i,
  input  logic cnt_any_i,
  output logic shift_o,
  output logic chr_clr_o,
  output logic cnt_clr_o,
  output logic wr_o,
  output logic done_o,
  output logic active_o
);
  localparam int MID  = SAMP_PER_ETU / 2;
  localparam int PMAX = (GAP_MAX_SAMP + 1 > SAMP_PER_ETU) ? GAP_MAX_SAMP + 1 : SAMP_PER_ETU;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int EMAX = (SOF_MAX_ETU + 1 > CHR_BITS) ? SOF_MAX_ETU + 1 : CHR_BITS;
  localparam int EW   = $clog2(EMAX + 1);

  sfr_state_e    st_q, st_d;
  logic [PW-1:0] pos_q, pos_d, pos_inc, pos_wrap;
  logic [EW-1:0] etu_q, etu_d;

  always_comb begin
    pos_inc   = pos_q + 1'b1;
    pos_wrap  = (pos_inc >= PW'(SAMP_PER_ETU)) ? '0 : pos_inc;
    st_d      = st_q;
    pos_d     = pos_q;
    etu_d     = etu_q;
    shift_o   = 1'b0;
    chr_clr_o = 1'b0;
    cnt_clr_o = 1'b0;
    wr_o      = 1'b0;
    done_o    = 1'b0;
    if (vld_i) begin
      unique case (st_q)
        SFR_IDLE: begin
          if (!bit_i) begin
            st_d  = SFR_SOF;
            pos_d = '0;
            etu_d = '0;
          end
        end
        SFR_SOF: begin
          pos_d = pos_wrap;
          if (pos_inc == PW'(MID)) begin
            if (bit_i) begin
              if (etu_q >= EW'(SOF_MIN_ETU)) begin
                st_d      = SFR_GAP;
                pos_d     = '0;
                cnt_clr_o = 1'b1;
              end else begin
                st_d = SFR_IDLE;
              end
            end else begin
              etu_d = etu_q + 1'b1;
              if (etu_q >= EW'(SOF_MAX_ETU)) st_d = SFR_IDLE;
            end
          end
        end
        SFR_GAP: begin
          if (bit_i) begin
            pos_d = pos_inc;
            if (pos_q >= PW'(GAP_MAX_SAMP)) st_d = SFR_IDLE;
          end else begin
            st_d      = SFR_CHR;
            pos_d     = PW'(1);
            etu_d     = '0;
            chr_clr_o = 1'b1;
          end
        end
        SFR_CHR: begin
          pos_d = pos_wrap;
          if (pos_inc == PW'(MID)) begin
            shift_o = 1'b1;
            etu_d   = etu_q + 1'b1;
            if (etu_q == EW'(CHR_BITS - 1)) begin
              if (chr_byte_i) begin
                wr_o = 1'b1;
                if (cnt_last_i) begin
                  st_d = SFR_IDLE;
                end else begin
                  st_d  = SFR_GAP;
                  pos_d = '0;
                end
              end else begin
                st_d   = SFR_IDLE;
                done_o = chr_end_i & cnt_any_i;
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SFR_IDLE;
      pos_q <= '0;
      etu_q <= '0;
    end else if (vld_i) begin
      st_q  <= st_d;
      pos_q <= pos_d;
      etu_q <= etu_d;
    end
  end

  always_comb active_o = (st_q == SFR_GAP) || (st_q == SFR_CHR);
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx #(
  parameter int SAMP_PER_ETU = 4,
  parameter int SOF_MIN_ETU  = 10,
  parameter int SOF_MAX_ETU  = 12,
  parameter int GAP_MAX_SAMP = 25,
  parameter int CHR_BITS     = 10,
  parameter int MAX_BYTES    = 256,
  localparam int AW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int CW = $clog2(MAX_BYTES + 1),
  localparam int DW = CHR_BITS - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp_vld_i,
  input  logic          samp_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          active_o,
  output logic          done_o,
  output logic [CW-1:0] done_len_o
);
  logic          shift, chr_clr, cnt_clr, wr_fire, done_fire;
  logic          chr_byte, chr_end, cnt_last, cnt_any;
  logic [DW-1:0] chr_data;
  logic [CW-1:0] cnt;

  sfr_ctl #(
    .SAMP_PER_ETU(SAMP_PER_ETU), .SOF_MIN_ETU(SOF_MIN_ETU), .SOF_MAX_ETU(SOF_MAX_ETU),
    .GAP_MAX_SAMP(GAP_MAX_SAMP), .CHR_BITS(CHR_BITS)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .vld_i(samp_vld_i), .bit_i(samp_i),
    .chr_byte_i(chr_byte), .chr_end_i(chr_end), .cnt_last_i(cnt_last), .cnt_any_i(cnt_any),
    .shift_o(shift), .chr_clr_o(chr_clr), .cnt_clr_o(cnt_clr), .wr_o(wr_fire),
    .done_o(done_fire), .active_o(active_o)
  );

  sfr_chr_shift #(.CHR_BITS(CHR_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr_i(chr_clr), .shift_i(shift), .bit_i(samp_i),
    .is_byte_o(chr_byte), .is_end_o(chr_end), .byte_o(chr_data)
  );

  sfr_byte_ctr #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(wr_fire),
    .cnt_o(cnt), .last_o(cnt_last), .any_o(cnt_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_o    <= 1'b0;
      done_o     <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      done_len_o <= '0;
    end else begin
      wr_en_o <= wr_fire;
      done_o  <= done_fire;
      if (wr_fire) begin
        wr_addr_o <= cnt[AW-1:0];
        wr_data_o <= chr_data;
      end
      if (done_fire) done_len_o <= cnt;
    end
  end
endmodule

// File: rtl/sfr_rx_chk.sv
module sfr_rx_chk #(
  parameter int AW        = 8,
  parameter int CW        = 9,
  parameter int MAX_BYTES = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          samp_vld_i,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic          active_o,
  input logic          done_o,
  input logic [CW-1:0] done_len_o
);
  // R7
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (done_len_o != '0));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7
  wr_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wr_en_o);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active_o);
  // R9
  wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (int'(wr_addr_o) < MAX_BYTES));
  // R9
  done_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (int'(done_len_o) < MAX_BYTES));
  // R12
  wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> $past(samp_vld_i));
endmodule

bind sfr_rx sfr_rx_chk #(.AW(AW), .CW(CW), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .samp_vld_i(samp_vld_i), .wr_en_o(wr_en_o),
  .wr_addr_o(wr_addr_o), .active_o(active_o), .done_o(done_o), .done_len_o(done_len_o)
);

// File: tb/tb_sfr_rx.sv
module tb_sfr_rx;
  localparam int MAXB = 6;
  localparam int GAPS = 25;
  localparam int AW   = $clog2(MAXB);
  localparam int CW   = $clog2(MAXB + 1);
  localparam int LOGN = 2048;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          samp_vld_i = 1'b0;
  logic          samp_i = 1'b1;
  logic          wr_en_o, active_o, done_o;
  logic [AW-1:0] wr_addr_o;
  logic [7:0]    wr_data_o;
  logic [CW-1:0] done_len_o;

  always #2 clk = ~clk;

  sfr_rx #(.MAX_BYTES(MAXB)) dut (
    .clk(clk), .rst_n(rst_n), .samp_vld_i(samp_vld_i), .samp_i(samp_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .active_o(active_o), .done_o(done_o), .done_len_o(done_len_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 0;

  // Output monitor: monotonic counters only, sampled away from the clock edge
  logic [7:0] got [0:LOGN-1];
  int wcnt = 0, dcnt = 0, dlen = 0, addr_bad = 0, act_cnt = 0, wofs = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en_o) begin
        if (int'(wr_addr_o) != wcnt - wofs) addr_bad++;
        got[wcnt % LOGN] = wr_data_o;
        wcnt++;
      end
      if (done_o) begin
        dcnt++;
        dlen = int'(done_len_o);
      end
      if (active_o) act_cnt++;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_sample(bit b);
    int nidle;
    @(negedge clk);
    samp_i = b;
    samp_vld_i = 1'b1;
    @(negedge clk);
    samp_vld_i = 1'b0;
    samp_i = 1'($urandom);
    nidle = int'($urandom_range(0, 2));
    for (int k = 0; k < nidle; k++) begin
      @(negedge clk);
      samp_i = 1'($urandom);
    end
  endtask

  task automatic send_etu(bit b);
    for (int k = 0; k < 4; k++) put_sample(b);
  endtask

  task automatic send_chr(logic [7:0] d, bit stopb);
    send_etu(1'b0);
    for (int k = 0; k < 8; k++) send_etu(d[k]);
    send_etu(stopb);
  endtask

  // Frame description
  int f_sof, f_tr, f_n, f_err;
  bit f_eof;
  logic [7:0] f_b [0:15];
  int f_g [0:15];

  task automatic set_frame(int sof, int tr, int n, int err, bit eof);
    f_sof = sof; f_tr = tr; f_n = n; f_err = err; f_eof = eof;
    for (int k = 0; k < 16; k++) begin
      f_b[k] = 8'($urandom);
      f_g[k] = 1;
    end
    if (err >= 0) f_b[err][0] = 1'b1;
  endtask

  task automatic run_frame(string req);
    int w0, d0, a0, en, nchk;
    bit edone, stop, vsof;
    w0 = wcnt; d0 = dcnt; a0 = act_cnt;
    wofs = wcnt;
    // R11: idle before a frame
    chk(active_o == 1'b0, "R11", int'(active_o), 0);
    for (int k = 0; k < f_sof; k++) send_etu(1'b0);
    for (int k = 0; k < f_tr; k++) send_etu(1'b1);
    vsof = (f_sof >= 10) && (f_sof <= 12);
    // R2 / R11: active after an accepted start-of-frame while the guard is within limit
    if (vsof && (4 * f_tr - 3 <= GAPS)) chk(active_o == 1'b1, "R2", int'(active_o), 1);
    for (int i = 0; i < f_n; i++) begin
      send_chr(f_b[i], (i == f_err) ? 1'b0 : 1'b1);
      if (i < f_n - 1 || f_eof) for (int k = 0; k < f_g[i]; k++) send_etu(1'b1);
    end
    if (f_eof) for (int k = 0; k < 10; k++) send_etu(1'b0);
    for (int k = 0; k < 10; k++) send_etu(1'b1);
    // Expected outcome from the requirements
    en = 0; edone = 0; stop = 0;
    if (!vsof || (4 * f_tr - 3 > GAPS)) stop = 1;
    for (int i = 0; i < f_n; i++) begin
      if (stop) break;
      if (i > 0 && (2 + 4 * f_g[i-1] > GAPS)) begin stop = 1; break; end
      if (i == f_err) begin stop = 1; break; end
      en++;
      if (en == MAXB) begin stop = 1; break; end
    end
    if (!stop && f_eof) begin
      if (f_n > 0 && (2 + 4 * f_g[f_n-1] > GAPS)) stop = 1;
      else if (en > 0) edone = 1;
    end
    chk(wcnt - w0 == en, req, wcnt - w0, en);
    nchk = (wcnt - w0 < en) ? wcnt - w0 : en;
    for (int i = 0; i < nchk; i++)
      chk(got[(w0 + i) % LOGN] == f_b[i], "R5", int'(got[(w0 + i) % LOGN]), int'(f_b[i]));
    chk(addr_bad == 0, "R5", addr_bad, 0);
    chk(dcnt - d0 == int'(edone), req, dcnt - d0, int'(edone));
    if (edone) begin
      chk(dlen == en, "R7", dlen, en);
      chk(act_cnt > a0, "R11", act_cnt - a0, 1);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!wr_en_o && !done_o && !active_o && done_len_o == '0, "R1",
        int'(wr_en_o) + int'(done_o) + int'(active_o) + int'(done_len_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_en_o && !done_o && !active_o && done_len_o == '0, "R1",
        int'(wr_en_o) + int'(done_o) + int'(active_o) + int'(done_len_o), 0);
    for (int k = 0; k < 5; k++) send_etu(1'b1);

    set_frame(10, 2, 1, -1, 1); f_b[0] = 8'hA5; run_frame("R2");
    set_frame(12, 3, 3, -1, 1); f_b[0] = 8'h00; f_b[1] = 8'hFF; f_b[2] = 8'h3C; run_frame("R5");
    set_frame(11, 2, MAXB - 1, -1, 1); run_frame("R7");
    set_frame(9, 2, 2, -1, 1); run_frame("R3");
    set_frame(13, 2, 2, -1, 1); run_frame("R4");
    set_frame(14, 2, 2, -1, 1); run_frame("R4");
    set_frame(11, 2, 0, -1, 1); run_frame("R8");
    set_frame(10, 2, 8, -1, 1); run_frame("R9");
    set_frame(10, 2, 3, -1, 1); f_g[0] = 5; f_g[1] = 5; f_g[2] = 5; run_frame("R6");
    set_frame(10, 2, 3, -1, 1); f_g[0] = 6; run_frame("R6");
    set_frame(10, 7, 2, -1, 1); run_frame("R6");
    set_frame(10, 8, 2, -1, 1); run_frame("R6");
    set_frame(11, 2, 3, 1, 1); run_frame("R10");

    // Random frames; noise on samp_i between strobes exercises R12
    for (int r = 0; r < 30; r++) begin
      set_frame(10 + int'($urandom_range(0, 2)), 2 + int'($urandom_range(0, 5)),
                1 + int'($urandom_range(0, 7)), -1, 1);
      for (int k = 0; k < 16; k++) f_g[k] = int'($urandom_range(0, 5));
      run_frame("R12");
    end

    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL R12 watchdog: got %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule